// File: doc/BRIEF.md
# Receive ring buffer frame writer

This block stores incoming Ethernet frames into a circular receive buffer that lives in local memory and is organised in 256-byte pages. Frames arrive as a byte stream, one byte per cycle, with a start marker on the first byte and an end marker on the last. The ring is bounded by a first page and a limit page. A boundary page marks how far software has read, and a current page marks where the next frame goes.

When a frame starts, the block checks two things. The buffer must be running, and there must be room for a frame of the largest size. If either check fails, the frame is discarded. Otherwise the payload is written from byte 4 of the current page onward, and the address wraps from the limit page back to the first page. After the end marker the block pads short frames with zeros. It then writes a 4-byte header in front of the payload and reports the page where the following frame will begin. During padding and the header the stream input is stalled.

The surrounding logic feeds the reported next page back into its current-page register. CRC checking and address filtering are handled elsewhere.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame whose first byte arrives while `halt` is 1 is discarded. `frame_drop` pulses for one cycle, there is no memory write and no `frame_done`, and the remaining bytes up to the end marker are accepted and thrown away.
- R2: The free space in bytes is 256*(bound-curr) when curr < bound, and otherwise 256*((limit-first)-(curr-bound)). A frame is discarded as in R1 when the free space is less than MAX_FRAME+4 (1518 by default).
- R3: An accepted frame's bytes are written in arrival order, one write per accepted byte. The first byte goes to address curr*256+4 and each further byte to the following address.
- R4: A payload or padding write never targets a page outside the range [first, limit). When the address would reach limit*256, it continues at first*256.
- R5: A frame shorter than 60 bytes gets zero bytes appended until it is 60 bytes long. `in_ready` is 0 from the cycle after the end marker is accepted until the header is complete.
- R6: After the payload and padding, four header bytes are written at curr*256 + 0, 1, 2, 3, in that order: status, next page, low byte of (padded length + 4), high byte of (padded length + 4).
- R7: The status byte has bit 0 set to 1 and bit 5 equal to bit 0 of the frame's first byte. All its other bits are 0. The same value appears on `rx_status` with `frame_done`.
- R8: The next page is curr + ceil((padded length + 8)/256). If that is at or above limit, (limit - first) is subtracted.
- R9: `frame_done` pulses for one cycle with the next page on `cur_next`, in the same cycle as the last header write.
- R10: After reset, `in_ready` is 1 and `mem_we`, `frame_done` and `frame_drop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Receiver stopped; frames are discarded |
| pg_first | input | 8 | First page of the ring |
| pg_limit | input | 8 | Page one past the end of the ring |
| pg_bound | input | 8 | Boundary page (oldest unread) |
| pg_curr | input | 8 | Current page, where the next frame is written |
| in_valid | input | 1 | Stream byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| frame_done | output | 1 | One-cycle pulse: frame stored |
| cur_next | output | 8 | New current page, valid with frame_done |
| rx_status | output | 8 | Status byte of the stored frame |
| frame_drop | output | 1 | One-cycle pulse: frame discarded |

## Verification
On every cycle, the assertions check four properties. Each write address stays inside the latched ring. A discard produces no writes. The reported next page lies inside the ring. The completion pulse is a single cycle and carries a good status.

Other behaviour can only be shown by the bench scenarios, which check the exact write sequence against a scoreboard:
- the admission threshold on both sides of the free-space formula;
- padding of short frames;
- wrapping at the limit page in the middle of a payload;
- page rounding at exactly 248 and 249 bytes;
- the header contents.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    parameter int PG_W   = 8;
    parameter int OFS_W  = 8;
    parameter int BYTE_W = 8;
    parameter int LEN_W  = 16;
    parameter int ADDR_W = PG_W + OFS_W;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RECV = 3'd1,
        ST_SKIP = 3'd2,
        ST_PAD  = 3'd3,
        ST_HDR  = 3'd4
    } wr_state_e;

    typedef struct packed {
        wr_state_e           st;
        logic [PG_W-1:0]     base_pg;
        logic [PG_W-1:0]     lo_pg;
        logic [PG_W-1:0]     hi_pg;
        logic [ADDR_W-1:0]   wr_addr;
        logic [LEN_W-1:0]    len;
        logic                grp;
        logic [1:0]          hdr_idx;
        logic                we;
        logic [ADDR_W-1:0]   waddr;
        logic [BYTE_W-1:0]   wdata;
        logic                done;
        logic                drop;
        logic [PG_W-1:0]     next_pg;
        logic [BYTE_W-1:0]   status;
    } wr_regs_t;
endpackage

// File: rtl/rxr_room_check.sv
module rxr_room_check
    import rxr_pkg::*;
#(
    parameter int NEED = 1518
) (
    input  logic [PG_W-1:0] pg_first,
    input  logic [PG_W-1:0] pg_limit,
    input  logic [PG_W-1:0] pg_bound,
    input  logic [PG_W-1:0] pg_curr,
    output logic            has_room
);
    localparam int FW = PG_W + 1 + OFS_W;

    logic [PG_W:0] free_pg;
    logic [FW-1:0] free_bytes;

    always_comb begin
        if (pg_curr < pg_bound) begin
            free_pg = {1'b0, pg_bound} - {1'b0, pg_curr};
        end else begin
            free_pg = ({1'b0, pg_limit} - {1'b0, pg_first})
                    - ({1'b0, pg_curr} - {1'b0, pg_bound});
        end
        free_bytes = {free_pg, {OFS_W{1'b0}}};
        has_room   = free_bytes >= FW'(NEED);
    end
endmodule

// File: rtl/rxr_addr_step.sv
module rxr_addr_step
    import rxr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [PG_W-1:0]   lo_pg,
    input  logic [PG_W-1:0]   hi_pg,
    output logic [ADDR_W-1:0] addr_nxt
);
    logic [ADDR_W-1:0] inc;

    always_comb begin
        inc = addr + ADDR_W'(1);
        if (inc == {hi_pg, {OFS_W{1'b0}}}) begin
            addr_nxt = {lo_pg, {OFS_W{1'b0}}};
        end else begin
            addr_nxt = inc;
        end
    end
endmodule

// File: rtl/rxr_next_page.sv
module rxr_next_page
    import rxr_pkg::*;
#(
    parameter int HDR_LEN = 4,
    parameter int CRC_LEN = 4
) (
    input  logic [PG_W-1:0]  base_pg,
    input  logic [PG_W-1:0]  lo_pg,
    input  logic [PG_W-1:0]  hi_pg,
    input  logic [LEN_W-1:0] len,
    output logic [PG_W-1:0]  next_pg,
    output logic [LEN_W-1:0] tot_len
);
    localparam int SW = LEN_W + 1;

    logic [SW-1:0] span, pages, sum, ring, wrapped;

    always_comb begin
        span    = SW'(len) + SW'(HDR_LEN + CRC_LEN) + SW'((1 << OFS_W) - 1);
        pages   = span >> OFS_W;
        sum     = SW'(base_pg) + pages;
        ring    = SW'(hi_pg) - SW'(lo_pg);
        wrapped = (sum >= SW'(hi_pg)) ? (sum - ring) : sum;
        next_pg = PG_W'(wrapped);
        tot_len = len + LEN_W'(HDR_LEN);
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int MIN_LEN   = 60,
    parameter int MAX_FRAME = 1514,
    parameter int HDR_LEN   = 4,
    parameter int CRC_LEN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic [PG_W-1:0]   pg_first,
    input  logic [PG_W-1:0]   pg_limit,
    input  logic [PG_W-1:0]   pg_bound,
    input  logic [PG_W-1:0]   pg_curr,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              frame_done,
    output logic [PG_W-1:0]   cur_next,
    output logic [BYTE_W-1:0] rx_status,
    output logic              frame_drop
);
    localparam int NEED = MAX_FRAME + HDR_LEN;

    wr_regs_t q, d;

    logic              has_room;
    logic [ADDR_W-1:0] addr_nxt;
    logic [PG_W-1:0]   nxt_pg;
    logic [LEN_W-1:0]  tot_len;
    logic              acc;
    logic [LEN_W-1:0]  len_inc;
    logic [BYTE_W-1:0] status_b;

    rxr_room_check #(.NEED(NEED)) u_room (
        .pg_first (pg_first),
        .pg_limit (pg_limit),
        .pg_bound (pg_bound),
        .pg_curr  (pg_curr),
        .has_room (has_room)
    );

    rxr_addr_step u_step (
        .addr     (q.wr_addr),
        .lo_pg    (q.lo_pg),
        .hi_pg    (q.hi_pg),
        .addr_nxt (addr_nxt)
    );

    rxr_next_page #(.HDR_LEN(HDR_LEN), .CRC_LEN(CRC_LEN)) u_npg (
        .base_pg (q.base_pg),
        .lo_pg   (q.lo_pg),
        .hi_pg   (q.hi_pg),
        .len     (q.len),
        .next_pg (nxt_pg),
        .tot_len (tot_len)
    );

    assign in_ready = (q.st == ST_IDLE) || (q.st == ST_RECV) || (q.st == ST_SKIP);
    assign acc      = in_valid && in_ready;
    assign len_inc  = q.len + LEN_W'(1);
    assign status_b = {2'b00, q.grp, 4'b0000, 1'b1};

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.done = 1'b0;
        d.drop = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (acc && in_sof) begin
                    if (halt || !has_room) begin
                        d.drop = 1'b1;
                        d.st   = in_eof ? ST_IDLE : ST_SKIP;
                    end else begin
                        d.base_pg = pg_curr;
                        d.lo_pg   = pg_first;
                        d.hi_pg   = pg_limit;
                        d.we      = 1'b1;
                        d.waddr   = {pg_curr, OFS_W'(HDR_LEN)};
                        d.wdata   = in_data;
                        d.grp     = in_data[0];
                        d.len     = LEN_W'(1);
                        d.wr_addr = {pg_curr, OFS_W'(HDR_LEN)} + ADDR_W'(1);
                        d.hdr_idx = 2'd0;
                        if (in_eof) begin
                            d.st = (MIN_LEN > 1) ? ST_PAD : ST_HDR;
                        end else begin
                            d.st = ST_RECV;
                        end
                    end
                end
            end
            ST_RECV: begin
                if (acc) begin
                    d.we      = 1'b1;
                    d.waddr   = q.wr_addr;
                    d.wdata   = in_data;
                    d.wr_addr = addr_nxt;
                    d.len     = len_inc;
                    if (in_eof) begin
                        d.st = (len_inc < LEN_W'(MIN_LEN)) ? ST_PAD : ST_HDR;
                    end
                end
            end
            ST_SKIP: begin
                if (acc && in_eof) begin
                    d.st = ST_IDLE;
                end
            end
            ST_PAD: begin
                d.we      = 1'b1;
                d.waddr   = q.wr_addr;
                d.wdata   = '0;
                d.wr_addr = addr_nxt;
                d.len     = len_inc;
                if (len_inc >= LEN_W'(MIN_LEN)) begin
                    d.st = ST_HDR;
                end
            end
            ST_HDR: begin
                d.we      = 1'b1;
                d.waddr   = {q.base_pg, {(OFS_W-2){1'b0}}, q.hdr_idx};
                d.hdr_idx = q.hdr_idx + 2'd1;
                unique case (q.hdr_idx)
                    2'd0:    d.wdata = status_b;
                    2'd1:    d.wdata = nxt_pg;
                    2'd2:    d.wdata = tot_len[7:0];
                    default: d.wdata = tot_len[15:8];
                endcase
                if (q.hdr_idx == 2'd3) begin
                    d.done    = 1'b1;
                    d.next_pg = nxt_pg;
                    d.status  = status_b;
                    d.st      = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_we     = q.we;
    assign mem_addr   = q.waddr;
    assign mem_wdata  = q.wdata;
    assign frame_done = q.done;
    assign cur_next   = q.next_pg;
    assign rx_status  = q.status;
    assign frame_drop = q.drop;

    AST_RING_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1 -: PG_W] >= q.lo_pg) && (mem_addr[ADDR_W-1 -: PG_W] < q.hi_pg)); // R4
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_drop |-> !mem_we && !frame_done); // R1
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP) |=> !mem_we); // R1
    AST_NEXT_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (cur_next >= q.lo_pg) && (cur_next < q.hi_pg)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R9
    AST_STATUS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> rx_status[0] && (rx_status[4:1] == 4'd0) && (rx_status[7:6] == 2'd0)); // R7
endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b0;
    logic [7:0]  pg_first = 8'h40, pg_limit = 8'h50, pg_bound = 8'h40, pg_curr = 8'h40;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, mem_we, frame_done, frame_drop;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, cur_next, rx_status;

    int checks = 0;
    int errors = 0;

    logic [23:0] exp_wr[$];
    string       exp_tag[$];
    logic [15:0] exp_done[$];
    int          exp_drops = 0;

    always #10 clk = ~clk;

    rx_ring_writer u_rx_ring_writer (
        .clk(clk), .rst_n(rst_n), .halt(halt),
        .pg_first(pg_first), .pg_limit(pg_limit), .pg_bound(pg_bound), .pg_curr(pg_curr),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .in_ready(in_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .frame_done(frame_done), .cur_next(cur_next), .rx_status(rx_status),
        .frame_drop(frame_drop)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: pops expected items as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (exp_wr.size() == 0) begin
                    check(1'b0, "R1 R3 unexpected write", {8'h0, mem_addr, mem_wdata}, 0);
                end else begin
                    logic [23:0] e;
                    string t;
                    e = exp_wr.pop_front();
                    t = exp_tag.pop_front();
                    check({mem_addr, mem_wdata} == e, t, {8'h0, mem_addr, mem_wdata}, {8'h0, e});
                end
            end
            if (frame_done) begin
                if (exp_done.size() == 0) begin
                    check(1'b0, "R9 unexpected done", {24'h0, cur_next}, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_done.pop_front();
                    check(cur_next == e[7:0], "R8 R9 next page", {24'h0, cur_next}, {24'h0, e[7:0]});
                    check(rx_status == e[15:8], "R7 status output", {24'h0, rx_status}, {24'h0, e[15:8]});
                end
            end
            if (frame_drop) begin
                check(exp_drops > 0, "R1 R2 unexpected drop", 1, 0);
                if (exp_drops > 0) exp_drops--;
            end
        end
    end

    task automatic push_wr(input logic [15:0] a, input logic [7:0] v, input string t);
        exp_wr.push_back({a, v});
        exp_tag.push_back(t);
    endtask

    // Driver: computes expected results from the requirements, then drives the frame
    task automatic send_frame(input int len, input logic [7:0] first, input bit keep);
        int plen;
        int tot;
        int nxt;
        logic [15:0] a;
        logic [7:0] st;
        if (keep) begin
            plen = (len < 60) ? 60 : len;
            tot = plen + 4;
            nxt = pg_curr + (plen + 8 + 255) / 256;
            if (nxt >= pg_limit) nxt = nxt - (pg_limit - pg_first);
            st = {2'b00, first[0], 5'b00001};
            a = {pg_curr, 8'h04};
            for (int i = 0; i < plen; i++) begin
                logic [7:0] v;
                v = (i == 0) ? first : ((i < len) ? 8'(i * 7 + 3) : 8'h00);
                push_wr(a, v, (i < len) ? "R3 R4 payload" : "R5 padding");
                a = a + 16'd1;
                if (a == {pg_limit, 8'h00}) a = {pg_first, 8'h00};
            end
            push_wr({pg_curr, 8'h00}, st, "R6 R7 header status");
            push_wr({pg_curr, 8'h01}, 8'(nxt), "R6 R8 header next");
            push_wr({pg_curr, 8'h02}, 8'(tot), "R6 header len lo");
            push_wr({pg_curr, 8'h03}, 8'(tot >> 8), "R6 header len hi");
            exp_done.push_back({st, 8'(nxt)});
        end else begin
            exp_drops++;
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_sof = (i == 0);
            in_eof = (i == len - 1);
            in_data = (i == 0) ? first : 8'(i * 7 + 3);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        if (keep) check(in_ready == 1'b0, "R5 ready low after end", {31'h0, in_ready}, 0);
        while (exp_wr.size() != 0 || exp_done.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_drops == 0, "R1 R2 drop pulse count", exp_drops, 0);
        if (keep) pg_curr = 8'(nxt);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !mem_we && !frame_done && !frame_drop, "R10 reset state",
              {in_ready, mem_we, frame_done, frame_drop}, 4'b1000);

        pg_bound = pg_curr; send_frame(100, 8'h10, 1);   // R3 R6 basic
        pg_bound = pg_curr; send_frame(10, 8'h01, 1);    // R5 R7 short, group bit
        pg_bound = pg_curr; send_frame(60, 8'h22, 1);    // R5 exactly minimum
        pg_bound = pg_curr; send_frame(248, 8'h33, 1);   // R8 one page exactly
        pg_bound = pg_curr; send_frame(249, 8'h35, 1);   // R8 two pages
        pg_bound = pg_curr; send_frame(1, 8'hFF, 1);     // R5 single byte
        pg_curr = 8'h4F; pg_bound = 8'h4F;
        send_frame(300, 8'h44, 1);                       // R4 R8 wrap at limit
        halt = 1'b1; pg_bound = pg_curr;
        send_frame(80, 8'h55, 0);                        // R1 halted
        send_frame(1, 8'h56, 0);                         // R1 single-byte drop
        halt = 1'b0;
        pg_curr = 8'h45; pg_bound = 8'h4A;
        send_frame(70, 8'h66, 0);                        // R2 below boundary, 5 pages
        pg_curr = 8'h45; pg_bound = 8'h4B;
        send_frame(70, 8'h67, 1);                        // R2 6 pages accepted
        pg_curr = 8'h4C; pg_bound = 8'h41;
        send_frame(70, 8'h68, 0);                        // R2 wrapped side, 5 pages
        pg_curr = 8'h4C; pg_bound = 8'h42;
        send_frame(64, 8'h69, 1);                        // R2 wrapped side, 6 pages
        pg_bound = pg_curr; send_frame(90, 8'h7A, 1);    // R3 back to normal after drops

        check(exp_wr.size() == 0, "R3 all writes seen", exp_wr.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule